// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block is a memory-mapped timer with several independent channels that share one prescaler and one start/stop register. Each channel holds a count, a compare value and a control/status word. While its run bit is set, a channel advances its count once per prescaler tick. When the count equals the compare value, the next tick returns the count to zero and sets the channel's match flag. The result is a periodic event with a period of compare+1 ticks. A channel with its interrupt enable set drives its interrupt line high for as long as the match flag stays set.

Software configures a channel in a fixed order. It stops the channel through the shared run register, which it updates by read-modify-write. It then presets the count, loads the compare value, sets up the control/status word and starts the channel again. The compare value may be rewritten while the channel runs. A build-time parameter selects a 16-bit or a 32-bit channel width. The width sets the data bus width, the register stride and the positions of the flag bits.

Top module: `cmpmatch_timer`

## Requirements
- R1: After reset all run bits, counts, flags and interrupt enables read zero, every compare register reads all ones, and every interrupt line is low.
- R2: On a tick where a running channel's count equals its compare value, the count becomes zero and the match flag (control/status bit W-1, W being the channel width) sets, so matches repeat every compare+1 ticks.
- R3: A running channel's count advances by exactly one per prescaler tick, and the prescaler produces one tick every 8 clock cycles.
- R4: Bit c of the shared start/stop register runs channel c when set. A channel whose bit is clear holds its count, and each channel's bit acts on that channel only.
- R5: Byte addresses: the start/stop register is at 0x00. Channel c occupies base 0x10*(c+1), with control/status at index 0, count at index 1 and compare at index 2. The byte offset of each is its index times 2 (16-bit build) or times 4 (32-bit build).
- R6: Writing 0 to a flag bit (W-1 match, W-2 wrap) clears it, and writing 1 leaves it unchanged. A flag event in the same cycle as a clearing write wins.
- R7: Control/status bit 5 enables the interrupt. A channel's interrupt line equals its match flag ANDed with that enable and stays high until the flag is cleared or the enable is dropped.
- R8: A compare write takes effect on the next tick. If the count is already above the new compare value, the count runs up to all ones and wraps to zero, setting the wrap flag (bit W-2) and not the match flag.
- R9: The count register is writable and reads back the written value, and a count write overrides any tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | AW | Byte address of the register access |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data of the addressed register (combinational) |
| irq_o | output | N_CH | Per-channel interrupt level |

## Verification
The embedded assertions check the following on every cycle:
- the count steps by one on each tick and holds between ticks and while the channel is stopped;
- a match returns the count to zero with the flag set;
- the prescaler never ticks on two adjacent cycles;
- an interrupt level never drops without a control/status write.

Some behaviour only the bench scenarios can show:
- the exact match period, measured across a sweep of compare values;
- the divide-by-8 rate measured over a long window;
- flag write-one-keeps and write-zero-clears behaviour;
- interrupt gating;
- isolation between channels;
- a compare value lowered below the count, which leads to a wrap with the wrap flag set, followed by a later match.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // register index inside a channel slot
  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_COUNT = 4'd1,
    REG_CMP   = 4'd2
  } reg_idx_e;

  localparam int IE_BIT   = 5;  // interrupt enable in control/status
  localparam int SLOT_LSB = 4;  // 16-byte slots: slot 0 = run register
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    tick_o = (pc_q == LAST);
    pc_d   = tick_o ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_spacing_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          csr_we_i,
  input  logic          cnt_we_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] csr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cmp_o,
  output logic          irq_o
);
  import cmt_pkg::*;

  localparam logic [CW-1:0] MAXV = '1;
  localparam int MF = CW - 1;  // match flag
  localparam int WF = CW - 2;  // wrap flag

  logic [CW-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic          match_q, match_d, wrap_q, wrap_d, ie_q, ie_d;
  logic          adv, hit_cmp, hit_max;

  always_comb begin
    adv     = run_i && tick_i && !cnt_we_i;
    hit_cmp = adv && (cnt_q == cmp_q);
    hit_max = adv && !hit_cmp && (cnt_q == MAXV);
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    match_d = match_q;
    wrap_d  = wrap_q;
    ie_d    = ie_q;
    if (adv) cnt_d = (hit_cmp || hit_max) ? '0 : cnt_q + 1'b1;
    if (cnt_we_i) cnt_d = wdata_i;
    if (cmp_we_i) cmp_d = wdata_i;
    if (csr_we_i) begin
      ie_d = wdata_i[IE_BIT];
      if (!wdata_i[MF]) match_d = 1'b0;
      if (!wdata_i[WF]) wrap_d  = 1'b0;
    end
    if (hit_cmp) match_d = 1'b1;
    if (hit_max) wrap_d  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cmp_q   <= MAXV;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
      match_q <= match_d;
      wrap_q  <= wrap_d;
      ie_q    <= ie_d;
    end
  end

  always_comb begin
    csr_o         = '0;
    csr_o[MF]     = match_q;
    csr_o[WF]     = wrap_q;
    csr_o[IE_BIT] = ie_q;
    cnt_o         = cnt_q;
    cmp_o         = cmp_q;
    irq_o         = match_q && ie_q;
  end

  assert_match_reload_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_we_i && cnt_q == cmp_q) |=> (cnt_q == '0 && match_q));
  assert_step_one_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_we_i && cnt_q != cmp_q && cnt_q != MAXV)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_idle_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!run_i || !tick_i) && !cnt_we_i) |=> $stable(cnt_q));
  assert_irq_level_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !csr_we_i) |=> irq_o);
  assert_wrap_flag_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_we_i && cnt_q == MAXV && cmp_q != MAXV)
      |=> (cnt_q == '0 && wrap_q));
endmodule

// File: rtl/cmpmatch_timer.sv
module cmpmatch_timer #(
  parameter int N_CH = 2,
  parameter bit WIDE = 1'b0,
  parameter int DIV  = 8,
  parameter int AW   = 8,
  localparam int CW  = WIDE ? 32 : 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   rdata_o,
  output logic [N_CH-1:0] irq_o
);
  import cmt_pkg::*;

  localparam int SH = WIDE ? 2 : 1;
  localparam int SW = AW - SLOT_LSB;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic          tick;
  logic [SW-1:0] slot;
  logic [3:0]    idx;
  logic          run_we;
  logic [N_CH-1:0] run_q, run_d;

  assign slot   = addr_i[AW-1:SLOT_LSB];
  assign idx    = addr_i[SLOT_LSB-1:0] >> SH;
  assign run_we = we_i && (slot == '0) && (idx == REG_CTRL);

  always_comb begin
    run_d = run_q;
    if (run_we) run_d = wdata_i[N_CH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  cmt_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  logic [CW-1:0] csr_v [N_CH];
  logic [CW-1:0] cnt_v [N_CH];
  logic [CW-1:0] cmp_v [N_CH];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam logic [SW-1:0] MY_SLOT = SW'(c + 1);
      logic hit;
      assign hit = we_i && (slot == MY_SLOT);
      cmt_channel #(.CW(CW)) u_ch (
        .clk_i    (clk_i),
        .rst_ni   (rst_n),
        .tick_i   (tick),
        .run_i    (run_q[c]),
        .csr_we_i (hit && idx == REG_CTRL),
        .cnt_we_i (hit && idx == REG_COUNT),
        .cmp_we_i (hit && idx == REG_CMP),
        .wdata_i  (wdata_i),
        .csr_o    (csr_v[c]),
        .cnt_o    (cnt_v[c]),
        .cmp_o    (cmp_v[c]),
        .irq_o    (irq_o[c])
      );
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (slot == '0 && idx == REG_CTRL) rdata_o[N_CH-1:0] = run_q;
    for (int c = 0; c < N_CH; c++) begin
      if (slot == SW'(c + 1)) begin
        case (idx)
          REG_CTRL:  rdata_o = csr_v[c];
          REG_COUNT: rdata_o = cnt_v[c];
          REG_CMP:   rdata_o = cmp_v[c];
          default:   rdata_o = '0;
        endcase
      end
    end
  end

  assert_run_write_R4 : assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_we |=> $stable(run_q));
endmodule

// File: tb/cmpmatch_timer_test.sv
`timescale 1ns/1ps
module cmpmatch_timer_test;
  localparam int W = 16;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [1:0]    irq;
  int            vecs = 0, bad = 0, cyc = 0;
  bit            done = 1'b0;

  // 16-bit map: run at 0x00, channel c at 0x10*(c+1): ctrl +0, count +2, compare +4
  localparam logic [7:0] RUN = 8'h00;
  function automatic logic [7:0] ra(int ch, int i);
    return 8'(16 * (ch + 1) + 2 * i);
  endfunction

  cmpmatch_timer uut (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
                      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(int ch);
    do @(negedge clk); while (!irq[ch]);
  endtask

  logic [W-1:0] v, v2;
  int t1, t2, tw;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(RUN, v); chk("R1 run", v, 0);
    for (int c = 0; c < 2; c++) begin
      rd(ra(c, 0), v); chk("R1 ctrl", v, 0);
      rd(ra(c, 1), v); chk("R1 count", v, 0);
      rd(ra(c, 2), v); chk("R1 compare", v, 16'hFFFF);
    end
    chk("R1 irq", irq, 0);

    // R2 / R5 period sweep on channel 0, compare 0..7
    for (int cv = 0; cv < 8; cv++) begin
      wr(RUN, 0); wr(ra(0, 0), 16'h0020); wr(ra(0, 1), 0); wr(ra(0, 2), W'(cv));
      wr(RUN, 1);
      wait_irq(0); t1 = cyc;
      rd(ra(0, 1), v); chk("R2 count zero after match", v, 0);
      wr(ra(0, 0), 16'h0020);
      wait_irq(0); t2 = cyc;
      chk("R2 period", t2 - t1, 8 * (cv + 1));
    end

    // R3 divide-by-8 rate
    wr(RUN, 0); wr(ra(0, 2), 16'hFFFF); wr(ra(0, 1), 0); wr(RUN, 1);
    repeat (5) @(negedge clk);
    rd(ra(0, 1), v); repeat (80) @(negedge clk); rd(ra(0, 1), v2);
    chk("R3 ticks in 80 cycles", v2 - v, 10);

    // R4 channel 1 stopped while channel 0 runs: holds; then both stopped
    rd(ra(1, 1), v); repeat (40) @(negedge clk); rd(ra(1, 1), v2);
    chk("R4 idle channel holds", v2, v);
    wr(RUN, 0); rd(ra(0, 1), v); repeat (40) @(negedge clk); rd(ra(0, 1), v2);
    chk("R4 stopped channel holds", v2, v);
    rd(RUN, v); chk("R4 run readback", v, 0);

    // R6/R7 flags and interrupt gating on channel 1 (enable off)
    wr(ra(1, 0), 0); wr(ra(1, 1), 0); wr(ra(1, 2), 2); wr(RUN, 2);
    repeat (40) @(negedge clk);
    wr(RUN, 0);
    rd(ra(1, 0), v); chk("R6 match flag set", v[15], 1);
    chk("R7 irq gated by enable", irq[1], 0);
    rd(ra(0, 1), v); rd(ra(0, 1), v2); chk("R4 channel 0 untouched", v2, v);
    wr(ra(1, 0), 16'hC000); rd(ra(1, 0), v); chk("R6 write one keeps", v[15], 1);
    wr(ra(1, 0), 16'hC020); @(negedge clk); chk("R7 irq with enable", irq[1], 1);
    wr(ra(1, 0), 16'h4020); rd(ra(1, 0), v);
    chk("R6 write zero clears", v[15], 0); chk("R7 irq drops", irq[1], 0);
    chk("R6 ie kept", v[5], 1);

    // R9 count writable; R8 compare below count leads to wrap
    wr(ra(0, 1), 16'hFFF0); rd(ra(0, 1), v); chk("R9 count readback", v, 16'hFFF0);
    wr(ra(0, 2), 5); wr(ra(0, 0), 16'h0020); wr(RUN, 1);
    tw = 0;
    for (int k = 0; k < 400 && tw == 0; k++) begin
      @(negedge clk); rd(ra(0, 0), v);
      if (v[14]) tw = cyc;
    end
    chk("R8 wrap flag set", tw != 0, 1);
    chk("R8 no match at wrap", v[15], 0);
    wait_irq(0); t1 = cyc;
    chk("R8 wrap to match ticks", t1 - tw, 48);
    // R8 raising compare right after a match applies to the running period
    wr(ra(0, 2), 9); wr(ra(0, 0), 16'h0020);
    wait_irq(0); t2 = cyc;
    chk("R8 new compare period", t2 - t1, 80);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule